// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the architectural register store of a 32-bit processor core that has several operating modes. The instruction set names sixteen registers. The block maps those register numbers onto 31 physical general registers, chosen by the mode field of the current status word that the block holds. It also keeps the current status word and one saved status word for each exception mode, so the block holds 37 physical words in all. Two read ports and one write port serve the datapath. A status write port lets the core rewrite the whole status word.

Two strobes handle exception traffic. The entry strobe names a target mode. In one clock it saves the current status into the target's saved status word, copies the program counter (register 15) into the target's link register (register 14), and switches the mode. The return strobe does the reverse. It restores the status word from the current mode's saved copy and loads register 15 from the current mode's link register.

The ports carry no handshake. Reads are combinational and every write is accepted on the clock edge. Because the block applies no back-pressure, the core must hold off any access it cannot issue in that cycle.

Top module: `banked_regfile`

## Requirements
- R1: After reset the status word reads 0x000000D3. This is supervisor mode with bit 7 (normal interrupt disable) and bit 6 (fast interrupt disable) set. Every general register and every saved status word reads zero.
- R2: Registers 0 to 7 and register 15 are one physical set seen from every mode.
- R3: Fast-interrupt mode (mode field 10001) has its own registers 8 to 12. All other modes share a single copy of registers 8 to 12.
- R4: The modes fast interrupt, interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) each have their own registers 13 and 14. User (10000) and system (11111) share one pair.
- R5: A mode field value outside the seven listed codes selects the user register set and has no saved status word.
- R6: Reads are combinational. A read of a register being written in the same cycle returns the old value, and the new value is visible from the next cycle.
- R7: Exception entry to a valid exception mode does four things in one clock. It copies the status word into the target's saved status word. It copies register 15 into the target's register 14. It sets the mode field (bits 4:0) to the target and sets bit 7. Fast-interrupt entry also sets bit 6. Bit 5 (compact instruction set) and all higher bits are kept. An entry strobe naming user, system or an unlisted code has no effect.
- R8: Exception return in an exception mode copies that mode's saved status word into the status word and its register 14 into register 15. In user or system mode a return strobe has no effect.
- R9: The saved-status output shows the saved status word of the current mode. In user, system or an unlisted mode it reads zero.
- R10: When several actions fall in one cycle, priority runs entry, then return, then status write. The register 14 or register 15 update of an entry or return wins over a general write to the same physical register. A general write maps its register number through the mode in force before the edge.
- R11: With no valid entry or return, a status write replaces the whole status word on the next edge. With no status-changing action at all, the status word holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_sel | input | 4 | Register number for read port A |
| rd_a_data | output | 32 | Read port A data (combinational) |
| rd_b_sel | input | 4 | Register number for read port B |
| rd_b_data | output | 32 | Read port B data (combinational) |
| wr_en | input | 1 | General write enable |
| wr_sel | input | 4 | Register number for the general write |
| wr_data | input | 32 | General write data |
| psr_wr_en | input | 1 | Status word write enable |
| psr_wr_data | input | 32 | New status word |
| exc_enter | input | 1 | Exception entry strobe |
| exc_target | input | 5 | Mode code to enter |
| exc_return | input | 1 | Exception return strobe |
| cur_psr | output | 32 | Current status word |
| saved_psr | output | 32 | Saved status word of the current mode |

## Verification
Exception entry and the general write port can act in the same cycle, and so can a return and a general write. The bench fires an entry, a return, a status write and a general write to register 14 on one edge from user mode. The entry must win the status word. The supervisor link register must receive the program counter, and the general write must still reach the user register 14. The bench then pairs a return with a general write to register 15. The return's restored program counter must win. Each outcome is read back through the read ports after the edge.

// File: rtl/banked_rf_pkg.sv
package banked_rf_pkg;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;

  localparam int NBANK     = 6;
  localparam int NPHYS     = 31;
  localparam int PAW       = $clog2(NPHYS);
  localparam int PC_NUM    = 15;
  localparam int LR_NUM    = 14;
  localparam int FIQ_BASE  = 16;  // fast-interrupt copies of r8..r12
  localparam int EXC_BASE  = 21;  // per-mode r13/r14 pairs

  localparam logic [4:0] MODE_USR = 5'b10000;
  localparam logic [4:0] MODE_FIQ = 5'b10001;
  localparam logic [4:0] MODE_IRQ = 5'b10010;
  localparam logic [4:0] MODE_SVC = 5'b10011;
  localparam logic [4:0] MODE_ABT = 5'b10111;
  localparam logic [4:0] MODE_UND = 5'b11011;
  localparam logic [4:0] MODE_SYS = 5'b11111;

  localparam int BIT_T = 5;
  localparam int BIT_F = 6;
  localparam int BIT_I = 7;

  function automatic logic [PAW-1:0] phys_idx(input bank_e b, input logic [3:0] r);
    logic [PAW-1:0] idx;
    if (r < 4'd8 || r == 4'(PC_NUM)) begin
      idx = PAW'(r);
    end else if (r < 4'd13) begin
      idx = (b == BK_FIQ) ? PAW'(r) + PAW'(FIQ_BASE - 8) : PAW'(r);
    end else if (b == BK_USR) begin
      idx = PAW'(r);
    end else begin
      idx = PAW'(EXC_BASE + 2 * (int'(b) - 1)) + ((r == 4'(LR_NUM)) ? PAW'(1) : PAW'(0));
    end
    return idx;
  endfunction

endpackage

// File: rtl/mode_decoder.sv
module mode_decoder
  import banked_rf_pkg::*;
(
  input  logic [4:0] mode,
  output bank_e      bank
);
  always_comb begin
    unique case (mode)
      MODE_FIQ: bank = BK_FIQ;
      MODE_IRQ: bank = BK_IRQ;
      MODE_SVC: bank = BK_SVC;
      MODE_ABT: bank = BK_ABT;
      MODE_UND: bank = BK_UND;
      default:  bank = BK_USR;
    endcase
  end
endmodule

// File: rtl/gpr_store.sv
module gpr_store #(
  parameter int W   = 32,
  parameter int N   = 31,
  parameter int NRD = 4,
  localparam int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_idx  [NRD],
  output logic [W-1:0]  rd_data [NRD],
  input  logic          gw_en,
  input  logic [AW-1:0] gw_idx,
  input  logic [W-1:0]  gw_data,
  input  logic          lw_en,
  input  logic [AW-1:0] lw_idx,
  input  logic [W-1:0]  lw_data
);
  logic [W-1:0] regs [N];

  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[i] <= '0;
      end else if (lw_en && lw_idx == AW'(i)) begin
        regs[i] <= lw_data;
      end else if (gw_en && gw_idx == AW'(i)) begin
        regs[i] <= gw_data;
      end
    end
  end

  for (genvar k = 0; k < NRD; k++) begin : g_rd
    assign rd_data[k] = regs[rd_idx[k]];
  end
endmodule

// File: rtl/psr_store.sv
module psr_store
  import banked_rf_pkg::*;
#(
  parameter int W = 32,
  parameter logic [W-1:0] RST_PSR = W'(8'hD3)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cpsr_we,
  input  logic [W-1:0] cpsr_d,
  output logic [W-1:0] cpsr_q,
  input  logic         spsr_we,
  input  bank_e        spsr_wsel,
  input  logic [W-1:0] spsr_d,
  input  bank_e        spsr_rsel,
  output logic [W-1:0] spsr_rd
);
  logic [W-1:0] spsr [NBANK];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cpsr_q <= RST_PSR;
    else if (cpsr_we) cpsr_q <= cpsr_d;
  end

  assign spsr[0] = '0;  // user/system set keeps no saved copy

  for (genvar b = 1; b < NBANK; b++) begin : g_spsr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      spsr[b] <= '0;
      else if (spsr_we && int'(spsr_wsel) == b)       spsr[b] <= spsr_d;
    end
  end

  assign spsr_rd = spsr[int'(spsr_rsel)];
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_rf_pkg::*;
#(
  parameter int W = 32,
  parameter logic [W-1:0] RST_PSR = W'(8'hD3)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   rd_a_sel,
  output logic [W-1:0] rd_a_data,
  input  logic [3:0]   rd_b_sel,
  output logic [W-1:0] rd_b_data,
  input  logic         wr_en,
  input  logic [3:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         psr_wr_en,
  input  logic [W-1:0] psr_wr_data,
  input  logic         exc_enter,
  input  logic [4:0]   exc_target,
  input  logic         exc_return,
  output logic [W-1:0] cur_psr,
  output logic [W-1:0] saved_psr
);
  localparam int NRD  = 4;
  localparam int P_A  = 0;
  localparam int P_B  = 1;
  localparam int P_PC = 2;
  localparam int P_LR = 3;

  bank_e cur_bank, tgt_bank;
  logic  enter_ok, ret_ok;

  logic [PAW-1:0] rd_idx  [NRD];
  logic [W-1:0]   rd_data [NRD];

  logic           lw_en;
  logic [PAW-1:0] lw_idx;
  logic [W-1:0]   lw_data;

  logic           cpsr_we;
  logic [W-1:0]   cpsr_d;

  mode_decoder u_cur_dec (.mode(cur_psr[4:0]), .bank(cur_bank));
  mode_decoder u_tgt_dec (.mode(exc_target),   .bank(tgt_bank));

  assign enter_ok = exc_enter && (tgt_bank != BK_USR);
  assign ret_ok   = exc_return && !enter_ok && (cur_bank != BK_USR);

  assign rd_idx[P_A]  = phys_idx(cur_bank, rd_a_sel);
  assign rd_idx[P_B]  = phys_idx(cur_bank, rd_b_sel);
  assign rd_idx[P_PC] = PAW'(PC_NUM);
  assign rd_idx[P_LR] = phys_idx(cur_bank, 4'(LR_NUM));

  assign rd_a_data = rd_data[P_A];
  assign rd_b_data = rd_data[P_B];

  // Link traffic of entry/return; beats the general write on a clash.
  always_comb begin
    lw_en   = enter_ok || ret_ok;
    lw_idx  = PAW'(PC_NUM);
    lw_data = rd_data[P_LR];
    if (enter_ok) begin
      lw_idx  = phys_idx(tgt_bank, 4'(LR_NUM));
      lw_data = rd_data[P_PC];
    end
  end

  always_comb begin
    cpsr_we = 1'b1;
    cpsr_d  = cur_psr;
    if (enter_ok) begin
      cpsr_d[4:0]   = exc_target;
      cpsr_d[BIT_I] = 1'b1;
      cpsr_d[BIT_F] = cur_psr[BIT_F] | (tgt_bank == BK_FIQ);
    end else if (ret_ok) begin
      cpsr_d = saved_psr;
    end else if (psr_wr_en) begin
      cpsr_d = psr_wr_data;
    end else begin
      cpsr_we = 1'b0;
    end
  end

  gpr_store #(.W(W), .N(NPHYS), .NRD(NRD)) u_gpr (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .gw_en   (wr_en),
    .gw_idx  (phys_idx(cur_bank, wr_sel)),
    .gw_data (wr_data),
    .lw_en   (lw_en),
    .lw_idx  (lw_idx),
    .lw_data (lw_data)
  );

  psr_store #(.W(W), .RST_PSR(RST_PSR)) u_psr (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpsr_we   (cpsr_we),
    .cpsr_d    (cpsr_d),
    .cpsr_q    (cur_psr),
    .spsr_we   (enter_ok),
    .spsr_wsel (tgt_bank),
    .spsr_d    (cur_psr),
    .spsr_rsel (cur_bank),
    .spsr_rd   (saved_psr)
  );
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         psr_wr_en,
  input logic [W-1:0] psr_wr_data,
  input logic         exc_enter,
  input logic [4:0]   exc_target,
  input logic         exc_return,
  input logic [W-1:0] cur_psr,
  input logic [W-1:0] saved_psr
);
  logic tgt_exc, cur_exc, ent_v, ret_v;
  assign tgt_exc = exc_target inside {5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011};
  assign cur_exc = cur_psr[4:0] inside {5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011};
  assign ent_v   = exc_enter && tgt_exc;
  assign ret_v   = exc_return && !ent_v && cur_exc;

  a_r7_entry_saves_status: assert property (@(posedge clk) disable iff (!rst_n)
    ent_v |=> saved_psr == $past(cur_psr));
  a_r7_entry_sets_mode: assert property (@(posedge clk) disable iff (!rst_n)
    ent_v |=> (cur_psr[4:0] == $past(exc_target)) && cur_psr[7]);
  a_r7_fast_entry_sets_f: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_v && exc_target == 5'b10001) |=> cur_psr[6]);
  a_r8_return_restores: assert property (@(posedge clk) disable iff (!rst_n)
    ret_v |=> cur_psr == $past(saved_psr));
  a_r9_no_saved_outside_exc: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_exc |-> saved_psr == '0);
  a_r11_status_write: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_wr_en && !ent_v && !ret_v) |=> cur_psr == $past(psr_wr_data));
  a_r11_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!psr_wr_en && !ent_v && !ret_v) |=> $stable(cur_psr));
endmodule

bind banked_regfile banked_regfile_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .psr_wr_en(psr_wr_en), .psr_wr_data(psr_wr_data),
  .exc_enter(exc_enter), .exc_target(exc_target), .exc_return(exc_return),
  .cur_psr(cur_psr), .saved_psr(saved_psr)
);

// File: tb/sim_banked_regfile.sv
`timescale 1ns/1ps
module sim_banked_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  rd_a_sel = '0, rd_b_sel = '0, wr_sel = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0, psr_wr_data = '0;
  logic        wr_en = 1'b0, psr_wr_en = 1'b0, exc_enter = 1'b0, exc_return = 1'b0;
  logic [4:0]  exc_target = '0;
  logic [31:0] cur_psr, saved_psr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  banked_regfile u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    wr_en = 0; psr_wr_en = 0; exc_enter = 0; exc_return = 0;
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk); clear_in(); #1;
  endtask

  task automatic wr_reg(input logic [3:0] s, input logic [31:0] d);
    wr_en = 1; wr_sel = s; wr_data = d; tick();
  endtask

  task automatic set_psr(input logic [31:0] v);
    psr_wr_en = 1; psr_wr_data = v; tick();
  endtask

  task automatic rd(input logic [3:0] s, output logic [31:0] v);
    rd_a_sel = s; #1; v = rd_a_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 status", cur_psr, 32'hD3);
    chk("R1 saved", saved_psr, 32'h0);
    rd(4'd0, v);  chk("R1 r0", v, 32'h0);
    rd(4'd13, v); chk("R1 r13", v, 32'h0);
  endtask

  task automatic t_shared();
    logic [31:0] v;
    wr_reg(4'd3, 32'hA5A5_0003);
    wr_reg(4'd15, 32'h0000_0100);
    set_psr(32'h10);
    chk("R11 status write", cur_psr, 32'h10);
    rd(4'd3, v);  chk("R2 r3 shared", v, 32'hA5A5_0003);
    rd(4'd15, v); chk("R2 r15 shared", v, 32'h0000_0100);
  endtask

  task automatic t_fiq_bank();
    logic [31:0] v;
    wr_reg(4'd8, 32'h800);
    set_psr(32'h11); rd(4'd8, v); chk("R3 fiq r8 own", v, 32'h0);
    wr_reg(4'd8, 32'hF8);
    set_psr(32'h12); rd(4'd8, v); chk("R3 irq r8 shared", v, 32'h800);
    set_psr(32'h11); rd(4'd8, v); chk("R3 fiq r8 kept", v, 32'hF8);
  endtask

  task automatic t_sp_bank();
    logic [31:0] v;
    set_psr(32'h12); wr_reg(4'd13, 32'h1300);
    set_psr(32'h13); rd(4'd13, v); chk("R4 svc r13 own", v, 32'h0);
    chk("R9 svc saved", saved_psr, 32'h0);
    set_psr(32'h10); wr_reg(4'd13, 32'h5);
    set_psr(32'h1F); rd(4'd13, v); chk("R4 sys shares user r13", v, 32'h5);
    chk("R9 sys saved zero", saved_psr, 32'h0);
    set_psr(32'h15); rd(4'd13, v); chk("R5 unlisted uses user r13", v, 32'h5);
    rd(4'd8, v); chk("R5 unlisted uses user r8", v, 32'h800);
    set_psr(32'h12); rd(4'd13, v); chk("R4 irq r13 kept", v, 32'h1300);
  endtask

  task automatic t_same_cycle();
    wr_en = 1; wr_sel = 4'd2; wr_data = 32'h22; rd_a_sel = 4'd2; rd_b_sel = 4'd2; #1;
    chk("R6 same-cycle old A", rd_a_data, 32'h0);
    chk("R6 same-cycle old B", rd_b_data, 32'h0);
    tick();
    chk("R6 next cycle new", rd_a_data, 32'h22);
  endtask

  task automatic t_entry();
    logic [31:0] v;
    set_psr(32'h30);
    wr_reg(4'd15, 32'h1000);
    exc_enter = 1; exc_target = 5'h12; tick();
    chk("R7 irq entry status", cur_psr, 32'hB2);
    chk("R7 irq entry saved", saved_psr, 32'h30);
    rd(4'd14, v); chk("R7 irq entry link", v, 32'h1000);
    exc_enter = 1; exc_target = 5'h11; tick();
    chk("R7 fiq entry status", cur_psr, 32'hF1);
    chk("R7 fiq entry saved", saved_psr, 32'hB2);
    rd(4'd14, v); chk("R7 fiq entry link", v, 32'h1000);
    exc_enter = 1; exc_target = 5'h10; tick();
    chk("R7 entry to user ignored", cur_psr, 32'hF1);
  endtask

  task automatic t_return();
    logic [31:0] v;
    wr_reg(4'd14, 32'h2000);
    exc_return = 1; tick();
    chk("R8 return status", cur_psr, 32'hB2);
    rd(4'd15, v); chk("R8 return pc", v, 32'h2000);
    exc_return = 1; tick();
    chk("R8 second return status", cur_psr, 32'h30);
    rd(4'd15, v); chk("R8 second return pc", v, 32'h1000);
    exc_return = 1; tick();
    chk("R8 user return ignored", cur_psr, 32'h30);
    rd(4'd15, v); chk("R8 user return pc kept", v, 32'h1000);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    exc_enter = 1; exc_target = 5'h13; exc_return = 1;
    psr_wr_en = 1; psr_wr_data = 32'h1F;
    wr_en = 1; wr_sel = 4'd14; wr_data = 32'hDEAD; tick();
    chk("R10 entry wins status", cur_psr, 32'hB3);
    chk("R10 entry saved", saved_psr, 32'h30);
    rd(4'd14, v); chk("R10 svc link from pc", v, 32'h1000);
    exc_return = 1; wr_en = 1; wr_sel = 4'd15; wr_data = 32'h7777; tick();
    chk("R10 return status", cur_psr, 32'h30);
    rd(4'd15, v); chk("R10 return beats pc write", v, 32'h1000);
    rd(4'd14, v); chk("R10 general write used old mode", v, 32'hDEAD);
    set_psr(32'h1F);
    chk("R11 status write sys", cur_psr, 32'h1F);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_shared();
    t_fiq_bank();
    t_sp_bank();
    t_same_cycle();
    t_entry();
    t_return();
    t_collide();
    finish_run();
  end
endmodule